// File: doc/BRIEF.md
# Instruction Field Splitter for Variable-Length Moves

This block receives one machine instruction at a time as a stream of bytes and breaks it into its fields. Leading size-override bytes are recorded, then a single opcode byte selects how many further bytes follow. Those bytes are, in order, a ModR/M byte, an optional scale-index-base (SIB) byte, displacement bytes and immediate bytes. After the last byte of an instruction, the decoded fields are presented together with a one-cycle `done` strobe.

A mode pin selects either 16-bit or 32-bit default sizes. The operand-size and address-size overrides flip these defaults for the current instruction only. The effective sizes decide how many displacement and immediate bytes are consumed and whether a SIB byte can appear.

The block recognises only a small group of opcodes: register/memory moves, segment-register moves, moves of an immediate into register/memory, and pushes of an immediate. Any other opcode raises `err`.

**Stream rules.** A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The decoder applies back-pressure only during the single cycle in which `done` is high. A producer that holds a byte during that cycle keeps it, and the byte is taken on the next edge. `in_valid` may drop between any two bytes, and decoding simply pauses.

Top module: `instr_field_decoder`

## Requirements
- R1: `in_ready` is low exactly in the cycle where `done` is high and high in every other cycle after reset. A byte offered while `in_ready` is low is not consumed and has no effect on any instruction.
- R2: `done` is high for exactly one cycle. That cycle is the one that follows the clock edge that took the instruction's final byte. The field outputs, including `opcode`, are valid in that cycle and keep their values until the next opcode byte is taken.
- R3: Byte 66h before the opcode flips the operand size and byte 67h flips the address size. The defaults are 16-bit when `mode32`=0 and 32-bit when `mode32`=1. `addr32` reports the effective address size. Both overrides are forgotten once the instruction completes or is rejected.
- R4: `op_size` is encoded as 0 for byte, 1 for word and 2 for dword. Opcodes 88h, 8Ah and C6h give a byte. Opcodes 89h, 8Bh and C7h, which have width bit 0 set, give the effective operand size, as do 68h and 6Ah. The segment moves 8Ch and 8Eh always give a word.
- R5: For opcodes 88h–8Bh, 8Ch and 8Eh, `dir` equals opcode bit 1 (1 means the R/M operand is the source). For every other opcode, `dir` is 0.
- R6: The byte after an 88h–8Bh, 8Ch, 8Eh, C6h or C7h opcode is split into `modrm_mod` (bits 7:6), `modrm_reg` (bits 5:3) and `modrm_rm` (bits 2:0). MOD=11b takes no displacement. For the push opcodes, all three fields read 0.
- R7: With 16-bit addressing, the displacement length is decided as follows. MOD=00b takes none, except R/M=110b, which takes 2 bytes as a direct address. MOD=01b takes 1 byte and MOD=10b takes 2 bytes. A SIB byte never follows.
- R8: A 1-byte displacement is sign-extended to the address size. Bits above the address size read 0, so 80h reads 0000FF80h under 16-bit addressing and FFFFFF80h under 32-bit addressing.
- R9: With 32-bit addressing, R/M=100b together with MOD≠11b takes a SIB byte. That byte gives `sib_index` (bits 5:3), `sib_base` (bits 2:0) and `sib_scale` = 1 shifted left by bits 7:6. MOD=10b takes 4 displacement bytes. MOD=00b takes 4 bytes when R/M=101b, or when the SIB base is 101b, and otherwise takes none.
- R10: Immediates depend on the opcode. C6h takes 1 byte. 6Ah takes 1 byte, sign-extended to the operand size. C7h and 68h take 2 or 4 bytes according to the operand size. Multi-byte displacements and immediates arrive least significant byte first, and unused upper bits read 0.
- R11: An opcode byte outside the supported set raises `err` for one cycle in the next cycle. In that case `done` stays low, the pending overrides are dropped, and the next byte is treated as the start of a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | Default size select (0: 16-bit, 1: 32-bit), held steady within an instruction |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| done | output | 1 | One-cycle strobe: field outputs hold a complete instruction |
| err | output | 1 | One-cycle strobe: unsupported opcode rejected |
| opcode | output | 8 | Opcode byte of the last accepted instruction |
| op_size | output | 2 | Effective data size: 0 byte, 1 word, 2 dword |
| addr32 | output | 1 | Effective address size is 32-bit |
| dir | output | 1 | Direction bit |
| modrm_mod | output | 2 | ModR/M mode field |
| modrm_reg | output | 3 | ModR/M register field |
| modrm_rm | output | 3 | ModR/M register/memory field |
| has_sib | output | 1 | A SIB byte was present |
| sib_scale | output | 4 | Index multiplier 1, 2, 4 or 8 (0 without SIB) |
| sib_index | output | 3 | SIB index register number |
| sib_base | output | 3 | SIB base register number |
| disp | output | 32 | Assembled and extended displacement |
| imm | output | 32 | Assembled and extended immediate |

## Verification
A wrong internal state shows up at the ports in one of two ways. A wrong byte count, whether for displacement, SIB or immediate, moves the `done` strobe earlier or later by whole cycles, so it is caught within a few cycles of the last byte. It also leaves the stream misaligned, so later instructions decode as garbage. A wrong size or extension decision does not move `done`. Instead it corrupts `op_size`, `disp` or `imm` in that very cycle, so every field is compared against an independent model at each strobe, and `done` and `in_ready` are compared on every cycle.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  typedef enum logic [2:0] {
    ST_OPC   = 3'd0,
    ST_MODRM = 3'd1,
    ST_SIB   = 3'd2,
    ST_DISP  = 3'd3,
    ST_IMM   = 3'd4,
    ST_EMIT  = 3'd5
  } ifd_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } opsz_e;

  localparam logic [7:0] BYTE_OPSZ_FLIP = 8'h66;
  localparam logic [7:0] BYTE_ADSZ_FLIP = 8'h67;
  localparam logic [7:0] OPC_PUSH_IB    = 8'h6A;
  localparam logic [7:0] OPC_PUSH_IW    = 8'h68;

  // Opcodes the splitter understands.
  function automatic logic op_known(input logic [7:0] op);
    case (op)
      8'h88, 8'h89, 8'h8A, 8'h8B,
      8'h8C, 8'h8E,
      8'hC6, 8'hC7,
      OPC_PUSH_IB, OPC_PUSH_IW: op_known = 1'b1;
      default:                  op_known = 1'b0;
    endcase
  endfunction

  // Every supported opcode except the pushes is followed by a ModR/M byte.
  function automatic logic op_has_modrm(input logic [7:0] op);
    op_has_modrm = (op != OPC_PUSH_IB) && (op != OPC_PUSH_IW);
  endfunction

endpackage

// File: rtl/ifd_size_sel.sv
module ifd_size_sel
  import ifd_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [7:0]       opcode,
  input  logic             op32,
  output opsz_e            op_size,
  output logic             dir,
  output logic [CNT_W-1:0] imm_len
);

  opsz_e            wide_sz;
  logic [CNT_W-1:0] wide_len;

  assign wide_sz  = op32 ? SZ_DWORD : SZ_WORD;
  assign wide_len = op32 ? CNT_W'(4) : CNT_W'(2);

  always_comb begin
    op_size = SZ_BYTE;
    dir     = 1'b0;
    imm_len = '0;
    case (opcode)
      8'h88, 8'h8A: begin
        op_size = SZ_BYTE;
        dir     = opcode[1];
      end
      8'h89, 8'h8B: begin
        op_size = wide_sz;
        dir     = opcode[1];
      end
      8'h8C, 8'h8E: begin
        op_size = SZ_WORD;
        dir     = opcode[1];
      end
      8'hC6: begin
        op_size = SZ_BYTE;
        imm_len = CNT_W'(1);
      end
      8'hC7: begin
        op_size = wide_sz;
        imm_len = wide_len;
      end
      OPC_PUSH_IB: begin
        op_size = wide_sz;
        imm_len = CNT_W'(1);
      end
      OPC_PUSH_IW: begin
        op_size = wide_sz;
        imm_len = wide_len;
      end
      default: begin
        op_size = SZ_BYTE;
      end
    endcase
  end

endmodule

// File: rtl/ifd_len_calc.sv
module ifd_len_calc #(
  parameter int CNT_W = 3
) (
  input  logic             a32,
  input  logic [1:0]       mod_f,
  input  logic [2:0]       rm_f,
  input  logic [2:0]       sib_base,
  input  logic             sib_seen,
  output logic             need_sib,
  output logic [CNT_W-1:0] disp_len
);

  assign need_sib = a32 && (mod_f != 2'b11) && (rm_f == 3'b100);

  always_comb begin
    disp_len = '0;
    case (mod_f)
      2'b01: disp_len = CNT_W'(1);
      2'b10: disp_len = a32 ? CNT_W'(4) : CNT_W'(2);
      2'b00: begin
        if (a32) begin
          if ((rm_f == 3'b101) ||
              (sib_seen && rm_f == 3'b100 && sib_base == 3'b101))
            disp_len = CNT_W'(4);
        end else if (rm_f == 3'b110) begin
          disp_len = CNT_W'(2);
        end
      end
      default: disp_len = '0;
    endcase
  end

  // R7: 16-bit addressing never asks for a SIB byte nor a 4-byte displacement
  always_comb begin
    if (!a32) begin
      assert (!need_sib && disp_len != CNT_W'(4))
        else $error("p_addr16_len_r7 violated");
    end
  end

endmodule

// File: rtl/ifd_field_acc.sv
module ifd_field_acc #(
  parameter int MAXB  = 4,
  parameter int CNT_W = 3,
  localparam int W    = 8 * MAXB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [7:0]       din,
  input  logic             sext8,
  input  logic             tgt32,
  output logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     val
);

  logic [W-1:0] raw;

  // One register per byte lane; the write count picks the lane (LSB first).
  for (genvar g = 0; g < MAXB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        raw[8*g +: 8] <= '0;
      else if (wr && cnt == CNT_W'(g))
        raw[8*g +: 8] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (wr)
      cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    if (!sext8)
      val = raw;
    else if (tgt32)
      val = {{(W-8){raw[7]}}, raw[7:0]};
    else
      val = {{(W-16){1'b0}}, {8{raw[7]}}, raw[7:0]};
  end

  // R10: the sequencer never writes past the last lane
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> cnt < CNT_W'(MAXB));

endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import ifd_pkg::*;
#(
  parameter int MAXB   = 4,
  localparam int FW    = 8 * MAXB,
  localparam int CNT_W = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode32,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          done,
  output logic          err,
  output logic [7:0]    opcode,
  output logic [1:0]    op_size,
  output logic          addr32,
  output logic          dir,
  output logic [1:0]    modrm_mod,
  output logic [2:0]    modrm_reg,
  output logic [2:0]    modrm_rm,
  output logic          has_sib,
  output logic [3:0]    sib_scale,
  output logic [2:0]    sib_index,
  output logic [2:0]    sib_base,
  output logic [FW-1:0] disp,
  output logic [FW-1:0] imm
);

  ifd_state_e       state;
  logic             pend_op, pend_ad;
  logic             op32_q, a32_q;
  logic [7:0]       opcode_q, modrm_q, sib_q;
  logic             has_sib_q, err_q;
  logic [CNT_W-1:0] disp_len_q;

  logic             accept, start, disp_wr, imm_wr;
  logic             need_sib_c;
  logic [CNT_W-1:0] disp_len_c, imm_len_c, disp_cnt, imm_cnt;
  logic [1:0]       mod_src;
  logic [2:0]       rm_src;
  opsz_e            op_size_c;
  logic             dir_c;
  ifd_state_e       after_disp;

  assign in_ready = (state != ST_EMIT);
  assign accept   = in_valid && in_ready;
  assign start    = accept && state == ST_OPC && in_data != BYTE_OPSZ_FLIP &&
                    in_data != BYTE_ADSZ_FLIP && op_known(in_data);
  assign disp_wr  = accept && state == ST_DISP;
  assign imm_wr   = accept && state == ST_IMM;

  // ModR/M comes straight off the stream in its own cycle, from the register after.
  assign mod_src  = (state == ST_MODRM) ? in_data[7:6] : modrm_q[7:6];
  assign rm_src   = (state == ST_MODRM) ? in_data[2:0] : modrm_q[2:0];

  ifd_len_calc #(.CNT_W(CNT_W)) u_len (
    .a32      (a32_q),
    .mod_f    (mod_src),
    .rm_f     (rm_src),
    .sib_base (in_data[2:0]),
    .sib_seen (state == ST_SIB),
    .need_sib (need_sib_c),
    .disp_len (disp_len_c)
  );

  ifd_size_sel #(.CNT_W(CNT_W)) u_size (
    .opcode  (opcode_q),
    .op32    (op32_q),
    .op_size (op_size_c),
    .dir     (dir_c),
    .imm_len (imm_len_c)
  );

  ifd_field_acc #(.MAXB(MAXB), .CNT_W(CNT_W)) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .wr    (disp_wr),
    .din   (in_data),
    .sext8 (disp_len_q == CNT_W'(1)),
    .tgt32 (a32_q),
    .cnt   (disp_cnt),
    .val   (disp)
  );

  ifd_field_acc #(.MAXB(MAXB), .CNT_W(CNT_W)) u_imm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .wr    (imm_wr),
    .din   (in_data),
    .sext8 (opcode_q == OPC_PUSH_IB),
    .tgt32 (op32_q),
    .cnt   (imm_cnt),
    .val   (imm)
  );

  assign after_disp = (imm_len_c != '0) ? ST_IMM : ST_EMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_OPC;
      pend_op    <= 1'b0;
      pend_ad    <= 1'b0;
      op32_q     <= 1'b0;
      a32_q      <= 1'b0;
      opcode_q   <= '0;
      modrm_q    <= '0;
      sib_q      <= '0;
      has_sib_q  <= 1'b0;
      disp_len_q <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_OPC: if (accept) begin
          if (in_data == BYTE_OPSZ_FLIP) begin
            pend_op <= 1'b1;
          end else if (in_data == BYTE_ADSZ_FLIP) begin
            pend_ad <= 1'b1;
          end else begin
            pend_op <= 1'b0;
            pend_ad <= 1'b0;
            if (op_known(in_data)) begin
              opcode_q   <= in_data;
              op32_q     <= mode32 ^ pend_op;
              a32_q      <= mode32 ^ pend_ad;
              modrm_q    <= '0;
              sib_q      <= '0;
              has_sib_q  <= 1'b0;
              disp_len_q <= '0;
              state      <= op_has_modrm(in_data) ? ST_MODRM : ST_IMM;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_MODRM: if (accept) begin
          modrm_q <= in_data;
          if (need_sib_c) begin
            state <= ST_SIB;
          end else begin
            disp_len_q <= disp_len_c;
            state      <= (disp_len_c != '0) ? ST_DISP : after_disp;
          end
        end
        ST_SIB: if (accept) begin
          sib_q      <= in_data;
          has_sib_q  <= 1'b1;
          disp_len_q <= disp_len_c;
          state      <= (disp_len_c != '0) ? ST_DISP : after_disp;
        end
        ST_DISP: if (accept && disp_cnt == disp_len_q - CNT_W'(1)) begin
          state <= after_disp;
        end
        ST_IMM: if (accept && imm_cnt == imm_len_c - CNT_W'(1)) begin
          state <= ST_EMIT;
        end
        ST_EMIT: state <= ST_OPC;
        default: state <= ST_OPC;
      endcase
    end
  end

  assign done      = (state == ST_EMIT);
  assign err       = err_q;
  assign opcode    = opcode_q;
  assign op_size   = op_size_c;
  assign addr32    = a32_q;
  assign dir       = dir_c;
  assign modrm_mod = modrm_q[7:6];
  assign modrm_reg = modrm_q[5:3];
  assign modrm_rm  = modrm_q[2:0];
  assign has_sib   = has_sib_q;
  assign sib_scale = has_sib_q ? (4'b0001 << sib_q[7:6]) : 4'b0000;
  assign sib_index = sib_q[5:3];
  assign sib_base  = sib_q[2:0];

  // R2: the completion strobe lasts one cycle and the stream reopens after it
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);

  // R11: a rejected opcode never coincides with a completion
  p_err_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

  // R9: a SIB byte only ever appears under 32-bit addressing with R/M=100b
  p_sib_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && has_sib) |-> (addr32 && modrm_mod != 2'b11 && modrm_rm == 3'b100 &&
                           $countones(sib_scale) == 1));

  // R4: byte-wide moves report a byte operand
  p_byte_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (opcode == 8'h88 || opcode == 8'h8A || opcode == 8'hC6)) |-> op_size == 2'd0);

  // R8: a one-byte displacement under 16-bit addressing leaves the top half clear
  p_disp_ext16_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !addr32 && modrm_mod == 2'b01) |->
      (disp[FW-1:16] == '0 && disp[15:8] == {8{disp[7]}}));

endmodule

// File: tb/instr_field_decoder_test.sv
module instr_field_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n, mode32, in_valid;
  logic [7:0]  in_data;
  logic        in_ready, done, err, addr32, dir, has_sib;
  logic [7:0]  opcode;
  logic [1:0]  op_size, modrm_mod;
  logic [2:0]  modrm_reg, modrm_rm, sib_index, sib_base;
  logic [3:0]  sib_scale;
  logic [31:0] disp, imm;

  always #10 clk = ~clk;

  instr_field_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .done(done), .err(err), .opcode(opcode), .op_size(op_size),
    .addr32(addr32), .dir(dir), .modrm_mod(modrm_mod), .modrm_reg(modrm_reg),
    .modrm_rm(modrm_rm), .has_sib(has_sib), .sib_scale(sib_scale),
    .sib_index(sib_index), .sib_base(sib_base), .disp(disp), .imm(imm)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected values from the behavioural model
  bit          e_err, e_a32, e_dir, e_sib;
  logic [7:0]  e_op;
  logic [1:0]  e_sz, e_mod;
  logic [2:0]  e_reg, e_rm, e_idx, e_base;
  logic [3:0]  e_scale;
  logic [31:0] e_disp, e_imm;

  task automatic model(bit m32, logic [7:0] q[$]);
    int   k = 0;
    bit   fo = 0, fa = 0, o32;
    int   dl = 0, il = 0;
    logic [7:0] s = 8'h00, m = 8'h00;
    while (q[k] == 8'h66 || q[k] == 8'h67) begin
      if (q[k] == 8'h66) fo = 1; else fa = 1;
      k++;
    end
    e_op = q[k]; k++;
    e_err = !(e_op inside {8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8E,
                            8'hC6, 8'hC7, 8'h68, 8'h6A});
    o32 = m32 ^ fo;
    e_a32 = m32 ^ fa;
    if (e_op inside {8'h88, 8'h8A, 8'hC6}) e_sz = 2'd0;
    else if (e_op inside {8'h8C, 8'h8E}) e_sz = 2'd1;
    else e_sz = o32 ? 2'd2 : 2'd1;
    e_dir = (e_op inside {8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8E}) ? e_op[1] : 1'b0;
    e_sib = 0;
    if (e_op != 8'h68 && e_op != 8'h6A) begin
      m = q[k]; k++;
      if (m[7:6] != 2'b11) begin
        if (e_a32) begin
          if (m[2:0] == 3'b100) begin e_sib = 1; s = q[k]; k++; end
          if (m[7:6] == 2'b01) dl = 1;
          else if (m[7:6] == 2'b10) dl = 4;
          else if ((!e_sib && m[2:0] == 3'b101) || (e_sib && s[2:0] == 3'b101)) dl = 4;
        end else begin
          if (m[7:6] == 2'b01) dl = 1;
          else if (m[7:6] == 2'b10) dl = 2;
          else if (m[2:0] == 3'b110) dl = 2;
        end
      end
    end
    e_mod = m[7:6]; e_reg = m[5:3]; e_rm = m[2:0];
    e_scale = e_sib ? (4'd1 << s[7:6]) : 4'd0;
    e_idx = s[5:3]; e_base = s[2:0];
    e_disp = 0;
    for (int j = 0; j < dl; j++) e_disp[8*j +: 8] = q[k + j];
    k += dl;
    if (dl == 1) e_disp = e_a32 ? {{24{e_disp[7]}}, e_disp[7:0]}
                                : {16'h0, {8{e_disp[7]}}, e_disp[7:0]};
    if (e_op == 8'hC6 || e_op == 8'h6A) il = 1;
    else if (e_op == 8'hC7 || e_op == 8'h68) il = o32 ? 4 : 2;
    e_imm = 0;
    for (int j = 0; j < il; j++) e_imm[8*j +: 8] = q[k + j];
    if (e_op == 8'h6A) e_imm = o32 ? {{24{e_imm[7]}}, e_imm[7:0]}
                                   : {16'h0, {8{e_imm[7]}}, e_imm[7:0]};
  endtask

  task automatic run(bit m32, logic [7:0] q[$], int gap, bit junk);
    model(m32, q);
    mode32 = m32;
    foreach (q[j]) begin
      if (gap > 0 && j > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "done during idle gap", done, 1'b0);
      end
      @(negedge clk);
      chk("R1", "in_ready mid-instruction", in_ready, 1'b1);
      if (j > 0) chk("R2", "done before last byte", done, 1'b0);
      in_valid = 1'b1;
      in_data  = q[j];
    end
    @(negedge clk);
    in_valid = junk;
    in_data  = 8'h66;
    if (e_err) begin
      chk("R11", "err strobe", err, 1'b1);
      chk("R11", "done on reject", done, 1'b0);
    end else begin
      chk("R2", "done after last byte", done, 1'b1);
      chk("R1", "in_ready during done", in_ready, 1'b0);
      chk("R2", "opcode", opcode, e_op);
      chk("R4", "op_size", op_size, e_sz);
      chk("R3", "addr32", addr32, e_a32);
      chk("R5", "dir", dir, e_dir);
      chk("R6", "modrm fields", {modrm_mod, modrm_reg, modrm_rm}, {e_mod, e_reg, e_rm});
      chk("R9", "sib fields", {has_sib, sib_scale, sib_index, sib_base},
          {e_sib, e_scale, e_idx, e_base});
      chk("R7,R8", "disp", disp, e_disp);
      chk("R10", "imm", imm, e_imm);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "done width", done, 1'b0);
    chk("R11", "err width", err, 1'b0);
    chk("R1", "in_ready after done", in_ready, 1'b1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; mode32 = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset in_ready", in_ready, 1'b1);
    chk("R2", "reset done", done, 1'b0);
    chk("R11", "reset err", err, 1'b0);
    chk("R2", "reset fields", {disp, imm}, 64'h0);

    // 16-bit mode: register form, direct, indirect, short displacements
    run(0, '{8'h8B, 8'hEC}, 0, 0);                    // R5 R6: reg-reg, dir=1
    run(0, '{8'h8A, 8'h15}, 0, 0);                    // R7: MOD=00 no disp
    run(0, '{8'h88, 8'h16, 8'h00, 8'h10}, 1, 0);      // R7: direct 16-bit, gaps
    run(0, '{8'h88, 8'h56, 8'h00}, 0, 0);             // R7: MOD=01 zero
    run(0, '{8'h88, 8'h56, 8'h80}, 0, 0);             // R8: FF80h
    run(0, '{8'h89, 8'h87, 8'h34, 8'h12}, 0, 0);      // R7: MOD=10 2 bytes
    // overrides flip both sizes in 16-bit mode, SIB scaled index
    run(0, '{8'h67, 8'h66, 8'h8B, 8'h04, 8'h8B}, 0, 0); // R3 R9
    run(0, '{8'hC7, 8'h87, 8'h00, 8'h10, 8'h34, 8'h12}, 0, 0); // R10 word imm
    run(0, '{8'h6A, 8'h08}, 0, 0);                    // R10 push byte
    run(0, '{8'h68, 8'h00, 8'h10}, 0, 0);             // R10 push word
    run(0, '{8'h8C, 8'hCB}, 0, 1);                    // R4 segment word; junk during done
    run(0, '{8'h8B, 8'hEC}, 0, 0);                    // R1 R3: junk 66h must be ignored
    // 32-bit mode
    run(1, '{8'h8B, 8'h05, 8'h44, 8'h33, 8'h22, 8'h11}, 0, 0); // R9 direct 32
    run(1, '{8'h8B, 8'h04, 8'h25, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 1, 0); // R9 base101
    run(1, '{8'h8B, 8'h44, 8'h24, 8'hF0}, 0, 0);      // R8 R9: FFFFFFF0h
    run(1, '{8'h8B, 8'h84, 8'hC8, 8'h78, 8'h56, 8'h34, 8'h12}, 0, 0); // R9 scale 8
    run(1, '{8'h66, 8'h89, 8'h08}, 0, 0);             // R3 R4: word in 32-bit mode
    run(1, '{8'h67, 8'h88, 8'h46, 8'h7F}, 0, 0);      // R3 R7: 16-bit addr in 32 mode
    run(1, '{8'h6A, 8'h80}, 0, 0);                    // R10 sign-extend to dword
    run(1, '{8'h68, 8'h78, 8'h56, 8'h34, 8'h12}, 0, 0); // R10 dword imm LSB first
    run(1, '{8'hC6, 8'h00, 8'h41}, 0, 0);             // R10 byte imm, R4 byte
    run(1, '{8'h8E, 8'hD8}, 0, 0);                    // R5 segment load dir=1
    // rejected opcode, prefix dropped afterwards
    run(0, '{8'h66, 8'h90}, 0, 0);                    // R11
    run(0, '{8'h89, 8'hC3}, 0, 0);                    // R11: word, override gone
    summary();
  end

endmodule